// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Control Path

This block is a small synchronous memory with a two-register access pipeline. Every control, address and data input is captured on a rising clock edge. The captured operation then reaches a word array and, for reads, an output register. Each word holds a parameterized number of byte lanes. Each lane is nine bits wide: eight data bits plus one parity bit, which the block stores as plain data. Writes can touch individual lanes through per-lane selects, or a global write can touch the whole word at once.

Three chip enables qualify every cycle: two are active high and one is active low. A deselected cycle neither writes nor drives. The output enable gates the per-lane drive-enables combinationally, with no clock involved. When a read arrives straight after a deselected cycle, its data slot is not driven. This keeps bank-expanded systems from colliding on a shared data bus while one device takes over from another.

Top module: `sync_pipe_sram`

## Requirements
- R1: While rst_ni is low, every bit of drv_o is 0.
- R2: A read sampled at edge k, where the cycle before it was selected, shows the addressed word on rdata_o after edge k+1, with drv_o all ones while oe_i is high.
- R3: With gw_i low and bwe_i high, only the lanes whose bsel_i bit is 1 are written. Lane i is wdata_i[9i+8:9i]. All other lanes keep their contents.
- R4: With gw_i low and bwe_i low, no lane is written whatever bsel_i holds, and the cycle is a read. The same holds when bsel_i is all zero.
- R5: With gw_i high, all lanes are written, whatever bwe_i and bsel_i hold.
- R6: A cycle is selected only when en_a_i=1, en_b_i=1 and en_c_ni=0. In any other combination it writes nothing.
- R7: While oe_i is low, drv_o is 0 in the same instant, without waiting for a clock edge.
- R8: A read sampled directly after a deselected cycle, or after reset, leaves drv_o at 0 for its data slot.
- R9: A deselected cycle sampled at edge k makes drv_o 0 after edge k+1, one cycle after the last read.
- R10: A read sampled on the edge right after a write to the same address returns the newly written lanes.
- R11: The data slot of a write cycle leaves drv_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_a_i | input | 1 | Chip enable, active high |
| en_b_i | input | 1 | Chip enable, active high |
| en_c_ni | input | 1 | Chip enable, active low |
| gw_i | input | 1 | Global write, writes every lane |
| bwe_i | input | 1 | Byte-write enable qualifying bsel_i |
| bsel_i | input | NB | Per-lane write selects |
| addr_i | input | AW | Word address |
| wdata_i | input | NB*BW | Write data, lane i at [9i+8:9i] |
| oe_i | input | 1 | Output enable, combinational |
| rdata_o | output | NB*BW | Registered read data |
| drv_o | output | NB | Per-lane drive-enable |

## Verification
The checker assumes that the enables are held in the deselected state for the whole of reset. A read on the first edge after reset is then masked as if it followed a deselect, and the $past-based drive rule never sees a stale selected cycle. The bench drives every input at the falling edge and holds the enables deselected throughout reset. It changes oe_i only between edges. Each data comparison follows a fill of every address, so no read is ever compared against uninitialised storage.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;
endpackage

// File: rtl/sram_in_stage.sv
module sram_in_stage
  import sram_pkg::*;
#(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int BW = 9,
  localparam int DW = NB * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_a_i,
  input  logic          en_b_i,
  input  logic          en_c_ni,
  input  logic          gw_i,
  input  logic          bwe_i,
  input  logic [NB-1:0] bsel_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output sram_op_e      op_o,
  output logic [AW-1:0] addr_o,
  output logic [NB-1:0] mask_o,
  output logic [DW-1:0] wdata_o,
  output logic          first_o
);
  logic          sel;
  logic [NB-1:0] mask_d;
  sram_op_e      op_d;

  assign sel    = en_a_i & en_b_i & ~en_c_ni;
  // global write beats the per-lane selects
  assign mask_d = gw_i ? {NB{1'b1}} : (bwe_i ? bsel_i : '0);

  always_comb begin
    if (!sel)        op_d = OP_IDLE;
    else if (|mask_d) op_d = OP_WRITE;
    else             op_d = OP_READ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o    <= OP_IDLE;
      addr_o  <= '0;
      mask_o  <= '0;
      wdata_o <= '0;
      first_o <= 1'b1;
    end else begin
      // first_o marks that the op now held follows an idle slot
      first_o <= (op_o == OP_IDLE);
      op_o    <= op_d;
      addr_o  <= addr_i;
      mask_o  <= sel ? mask_d : '0;
      wdata_o <= wdata_i;
    end
  end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int BW = 9,
  localparam int DW = NB * BW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic [NB-1:0] we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BW-1:0] bank [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[b]) bank[addr_i] <= wdata_i[b*BW +: BW];
    end

    assign rdata_o[b*BW +: BW] = bank[addr_i];
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
  parameter int NB = 4,
  parameter int BW = 9,
  localparam int DW = NB * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          first_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          oe_i,
  output logic [DW-1:0] rdata_o,
  output logic [NB-1:0] drv_o
);
  logic [DW-1:0] data_q;
  logic          drv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      drv_q  <= 1'b0;
    end else begin
      if (rd_i) data_q <= rdata_i;
      // a read emerging from deselect keeps its slot undriven
      drv_q <= rd_i & ~first_i;
    end
  end

  assign rdata_o = data_q;
  assign drv_o   = {NB{oe_i & drv_q}};
endmodule

// File: rtl/sync_pipe_sram.sv
module sync_pipe_sram
  import sram_pkg::*;
#(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int BW = 9,
  localparam int DW = NB * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_a_i,
  input  logic          en_b_i,
  input  logic          en_c_ni,
  input  logic          gw_i,
  input  logic          bwe_i,
  input  logic [NB-1:0] bsel_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          oe_i,
  output logic [DW-1:0] rdata_o,
  output logic [NB-1:0] drv_o
);
  sram_op_e      s1_op;
  logic [AW-1:0] s1_addr;
  logic [NB-1:0] s1_mask;
  logic [DW-1:0] s1_wdata;
  logic          s1_first;
  logic [DW-1:0] arr_rdata;
  logic [NB-1:0] arr_we;
  logic          s1_rd;

  sram_in_stage #(.AW(AW), .NB(NB), .BW(BW)) u_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_a_i  (en_a_i),
    .en_b_i  (en_b_i),
    .en_c_ni (en_c_ni),
    .gw_i    (gw_i),
    .bwe_i   (bwe_i),
    .bsel_i  (bsel_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .op_o    (s1_op),
    .addr_o  (s1_addr),
    .mask_o  (s1_mask),
    .wdata_o (s1_wdata),
    .first_o (s1_first)
  );

  assign arr_we = (s1_op == OP_WRITE) ? s1_mask : '0;
  assign s1_rd  = (s1_op == OP_READ);

  sram_array #(.AW(AW), .NB(NB), .BW(BW)) u_arr (
    .clk_i   (clk_i),
    .we_i    (arr_we),
    .addr_i  (s1_addr),
    .wdata_i (s1_wdata),
    .rdata_o (arr_rdata)
  );

  sram_out_stage #(.NB(NB), .BW(BW)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (s1_rd),
    .first_i (s1_first),
    .rdata_i (arr_rdata),
    .oe_i    (oe_i),
    .rdata_o (rdata_o),
    .drv_o   (drv_o)
  );
endmodule

// File: rtl/sync_pipe_sram_chk.sv
module sync_pipe_sram_chk #(
  parameter int NB = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_a_i,
  input logic          en_b_i,
  input logic          en_c_ni,
  input logic          gw_i,
  input logic          bwe_i,
  input logic [NB-1:0] bsel_i,
  input logic          oe_i,
  input logic [NB-1:0] drv_o
);
  logic sel_w;
  logic rd_w;

  assign sel_w = en_a_i & en_b_i & ~en_c_ni;
  assign rd_w  = sel_w & ~gw_i & ~(bwe_i & (|bsel_i));

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (drv_o == '0)); // R1

  AST_READ_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_w && $past(sel_w)) |-> ##2 (drv_o == {NB{oe_i}})); // R2

  AST_DESEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_w |-> ##2 (drv_o == '0)); // R9

  AST_OE_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (drv_o == '0)); // R7

  AST_FIRST_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_w ##1 rd_w) |-> ##2 (drv_o == '0)); // R8

  AST_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_w && !rd_w) |-> ##2 (drv_o == '0)); // R11
endmodule

bind sync_pipe_sram sync_pipe_sram_chk #(.NB(NB)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_a_i  (en_a_i),
  .en_b_i  (en_b_i),
  .en_c_ni (en_c_ni),
  .gw_i    (gw_i),
  .bwe_i   (bwe_i),
  .bsel_i  (bsel_i),
  .oe_i    (oe_i),
  .drv_o   (drv_o)
);

// File: tb/sync_pipe_sram_tb.sv
module sync_pipe_sram_tb;
  localparam int CLK_P = 10;
  localparam int AW = 4;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_a_i = 1'b0, en_b_i = 1'b0, en_c_ni = 1'b1;
  logic          gw_i = 1'b0, bwe_i = 1'b0, oe_i = 1'b1;
  logic [NB-1:0] bsel_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic [NB-1:0] drv_o;

  int checks = 0;
  int fails = 0;

  // reference pipeline and memory
  logic [DW-1:0] model [DEPTH];
  logic          s1_sel = 1'b0, s1_rd = 1'b0, prev_sel = 1'b0;
  logic [NB-1:0] s1_mask = '0;
  logic [AW-1:0] s1_addr = '0;
  logic [DW-1:0] s1_wd = '0;
  string         s1_tag = "R1";
  logic          exp_drv = 1'b0;
  logic [DW-1:0] exp_data = '0;
  string         out_tag = "R1";

  always #(CLK_P/2) clk_i = ~clk_i;

  sync_pipe_sram #(.AW(AW), .NB(NB), .BW(BW)) u_dut (.*);

  task automatic chk_drv(input string tag);
    logic [NB-1:0] e;
    e = {NB{oe_i & exp_drv}};
    checks++;
    if (drv_o !== e) begin
      fails++;
      $display("FAIL %s drv_o got=%b exp=%b", tag, drv_o, e);
    end
    if (oe_i && exp_drv) begin
      checks++;
      if (rdata_o !== exp_data) begin
        fails++;
        $display("FAIL %s rdata_o got=%h exp=%h", tag, rdata_o, exp_data);
      end
    end
  endtask

  task automatic step(input logic a, input logic b, input logic cn,
                      input logic gw, input logic bwe, input logic [NB-1:0] bs,
                      input logic [AW-1:0] ad, input logic [DW-1:0] wd,
                      input string tag);
    logic          sel;
    logic [NB-1:0] m;
    @(negedge clk_i);
    en_a_i = a; en_b_i = b; en_c_ni = cn;
    gw_i = gw; bwe_i = bwe; bsel_i = bs; addr_i = ad; wdata_i = wd;
    @(posedge clk_i);
    exp_drv = s1_sel && s1_rd && prev_sel;
    if (s1_sel && s1_rd) exp_data = model[s1_addr];
    if (s1_sel && !s1_rd)
      for (int i = 0; i < NB; i++)
        if (s1_mask[i]) model[s1_addr][i*BW +: BW] = s1_wd[i*BW +: BW];
    out_tag  = s1_tag;
    prev_sel = s1_sel;
    sel      = a & b & ~cn;
    m        = gw ? {NB{1'b1}} : (bwe ? bs : '0);
    s1_sel   = sel;
    s1_rd    = (m == '0);
    s1_mask  = m;
    s1_addr  = ad;
    s1_wd    = wd;
    s1_tag   = tag;
    #1;
    chk_drv(out_tag);
  endtask

  task automatic rd(input logic [AW-1:0] ad, input string tag);
    step(1, 1, 0, 0, 0, '0, ad, '0, tag);
  endtask

  task automatic idle(input string tag);
    step(0, 1, 0, 0, 0, '0, '0, '0, tag);
  endtask

  function automatic logic [DW-1:0] pat(input int s);
    return DW'(s) * 36'h0_9E37_79B1 ^ 36'h5_A5C3_3C5A;
  endfunction

  initial begin
    #(CLK_P * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: quiet during reset
    repeat (3) @(posedge clk_i);
    #1;
    checks++;
    if (drv_o !== '0) begin
      fails++;
      $display("FAIL R1 drv_o got=%b exp=0", drv_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R5: fill every word by global write (selects and bwe left low)
    for (int a = 0; a < DEPTH; a++) step(1, 1, 0, 1, 0, '0, AW'(a), pat(a), "R5");
    // R2: sequential reads, the first follows a selected write slot
    for (int a = 0; a < DEPTH; a++) rd(AW'(a), "R2");
    // R3/R10: every lane-select pattern, then read back on the next edge
    for (int m = 0; m < (1 << NB); m++) begin
      step(1, 1, 0, 0, 1, NB'(m), AW'(m), pat(m + 100), "R3");
      rd(AW'(m), "R10");
    end
    // R4: byte-write enable low with all selects, then with bwe high and no selects
    step(1, 1, 0, 0, 0, '1, 4'd3, pat(500), "R4");
    rd(4'd3, "R4");
    step(1, 1, 0, 0, 1, '0, 4'd3, pat(501), "R4");
    rd(4'd3, "R4");
    // R5: global write overrides partial selects
    step(1, 1, 0, 1, 1, 4'b0001, 4'd5, pat(600), "R5");
    rd(4'd5, "R5");
    rd(4'd5, "R5");
    // R6: all chip-enable combinations attempt a write, then two reads
    for (int c = 0; c < 8; c++) begin
      step(c[0], c[1], c[2], 1, 0, '0, 4'd7, pat(700 + c), "R6");
      rd(4'd7, "R6");
      rd(4'd7, "R6");
    end
    // R8: read straight after a deselect is masked, the next one drives
    idle("R9");
    rd(4'd1, "R8");
    rd(4'd2, "R8");
    // R9: deselect right after reads
    rd(4'd4, "R9");
    idle("R9");
    idle("R9");
    // R11: write slot between reads stays undriven
    rd(4'd6, "R11");
    step(1, 1, 0, 0, 1, 4'b1010, 4'd6, pat(800), "R11");
    rd(4'd6, "R11");
    rd(4'd6, "R11");
    // R7: output enable drops mid-cycle while a read slot is driving
    #2;
    oe_i = 1'b0;
    #1;
    checks++;
    if (drv_o !== '0) begin
      fails++;
      $display("FAIL R7 drv_o got=%b exp=0", drv_o);
    end
    oe_i = 1'b1;
    #1;
    chk_drv("R7");
    idle("R9");
    idle("R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule